// File: doc/BRIEF.md
# Shared-Bus Flash and Pseudo-SRAM Access Controller

This block sits on the host side of one address bus and one 16-bit data bus. Two memory dies share both buses: a NOR-style flash and a pseudo-SRAM. The host gives one request at a time. A request carries a target select, a write flag, a word address, write data and byte enables. The controller runs an asynchronous single-word bus cycle on the chosen die and returns one `done` pulse. On a read, the data arrives with that pulse. At no time does it enable both dies together.

Each bus cycle has a setup phase, an enable pulse and a hold phase. Each phase lasts a set number of system-clock cycles, given by a parameter. The controller leaves a turnaround cycle with the bus released when consecutive accesses change die or direction. It drives the flash address-latch strobe and the flash hardware reset. It also drives the PSRAM deep power-down select. It refuses requests that the dies cannot serve: a PSRAM address above 20 bits, any PSRAM access during power-down, and any flash access while the flash is held in reset. The first flash access after reset is released starts with an extra idle cycle, so that chip enable has a clean falling edge.

The state machine has these states:

- `ST_IDLE` waits for a request.
- `ST_GAP` is the turnaround cycle.
- `ST_SETUP`, `ST_PULSE` and `ST_HOLD` are the three bus phases.
- `ST_DONE` completes a served access.
- `ST_FAULT` completes a refused request.

Its transitions are:

- IDLE→FAULT on a refused request.
- IDLE→GAP on a request that needs turnaround.
- IDLE→SETUP otherwise.
- GAP→SETUP after one cycle.
- SETUP→PULSE, PULSE→HOLD and HOLD→DONE, each when its phase counter expires.
- DONE→IDLE and FAULT→IDLE after one cycle.

Top module: `fpb_shared_bus_ctrl`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n`, `fl_we_n`, `fl_adv_n`, `ps_ce1_n`, `ps_oe_n` and `ps_we_n` are 1, `fl_rst_n` and `ps_ce2` are 1, `dq_oe` is 00 and `busy` is 0.
- R2: An accepted, served request raises `done` for exactly one cycle. This happens SETUP_CYC+PULSE_CYC+HOLD_CYC clock edges after the accepting edge, plus one edge when a turnaround cycle is inserted. A read returns its data on `rdata` with `done`, and a write returns 0.
- R3: `fl_ce_n`=0 never occurs together with `ps_ce1_n`=0 and `ps_ce2`=1.
- R4: While either die has its output enable low, the other die's output enable is high and `dq_oe` is 00.
- R5: For a flash access, `fl_adv_n` is low during setup and pulse and high at all other times. It is low whenever `fl_ce_n` is low, and `mem_addr` is unchanged across its rising edge.
- R6: On a flash write, `mem_addr` and `dq_out` stay unchanged with both lanes driven across the rising edge of `fl_we_n`/`fl_ce_n`.
- R7: `req_be` bit 1 selects lane 15..8 (`ps_ub_n`, `dq_oe[1]`) and bit 0 selects lane 7..0 (`ps_lb_n`, `dq_oe[0]`). A PSRAM write drives only the selected lanes. A PSRAM read returns 0 in the unselected lanes.
- R8: A PSRAM request with any of `req_addr[22:20]` set is refused with `err`=1. Its `done` comes on the accepting edge, with no chip enable asserted. Flash requests use all 23 bits.
- R9: While `pwrdn_req` is 1 (sampled in idle), `ps_ce2` is 0, `ps_ce1_n` stays 1, and PSRAM requests are refused as in R8.
- R10: While `flash_rst_req` is 1 (sampled in idle), `fl_rst_n` is 0, `fl_ce_n` stays 1, and flash requests are refused. The first flash access after release gets a turnaround cycle even when target and direction are unchanged.
- R11: A turnaround cycle, with all enables high and `dq_oe`=00, is inserted when target or write flag differs from the previous served access. No turnaround cycle is inserted when both match. Refused requests do not count as previous accesses.
- R12: `busy` is 1 from the accepting edge until the cycle after `done`. `req_valid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 1 | 0 = flash, 1 = PSRAM |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high (bit 1 upper lane) |
| pwrdn_req | input | 1 | Hold PSRAM in deep power-down |
| flash_rst_req | input | 1 | Hold flash in hardware reset |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with done |
| rdata | output | 16 | Read data, valid with done |
| mem_addr | output | 23 | Shared address bus |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 2 | Per-lane data bus drive enable |
| dq_in | input | 16 | Data bus input value |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_adv_n | output | 1 | Flash address latch strobe, low = transparent |
| fl_rst_n | output | 1 | Flash hardware reset, active low |
| ps_ce1_n | output | 1 | PSRAM select, active low |
| ps_ce2 | output | 1 | PSRAM power select, low = deep power-down |
| ps_oe_n | output | 1 | PSRAM output enable, active low |
| ps_we_n | output | 1 | PSRAM write enable, active low |
| ps_ub_n | output | 1 | PSRAM upper byte enable, active low |
| ps_lb_n | output | 1 | PSRAM lower byte enable, active low |

## Verification
The bench builds the controller with setup 2, pulse 3 and hold 1 cycles. Each phase length is distinct, so any phase that runs long or short changes the measured completion latency. Served accesses take 6 edges, turnaround accesses take 7, and refusals take 0. Every scoreboard comparison therefore also shows whether a turnaround cycle was inserted. The small phase counts keep each access short. This lets one run cover the following:

- die switches and direction changes
- byte-lane writes
- refused addresses
- power-down and flash reset entry and exit
- a request arriving while the controller is busy

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_GAP, ST_SETUP, ST_PULSE, ST_HOLD, ST_DONE, ST_FAULT
    } fpb_state_e;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_PSRAM = 1'b1
    } fpb_tgt_e;
endpackage

// File: rtl/fpb_req_check.sv
module fpb_req_check
    import fpb_pkg::*;
#(
    parameter int HI_W = 3
) (
    input  fpb_tgt_e          tgt,
    input  logic              wr,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic              pd,
    input  logic              frst,
    input  logic              last_valid,
    input  fpb_tgt_e          last_tgt,
    input  logic              last_wr,
    input  logic              reexit,
    output logic              refuse,
    output logic              need_gap
);
    always_comb begin
        if (tgt == TGT_PSRAM) begin
            refuse = (addr_hi != '0) || pd;
        end else begin
            refuse = frst;
        end
        need_gap = (last_valid && ((tgt != last_tgt) || (wr != last_wr)))
                 || ((tgt == TGT_FLASH) && reexit);
    end
endmodule

// File: rtl/fpb_timer.sv
module fpb_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpb_pin_drive.sv
module fpb_pin_drive
    import fpb_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fpb_state_e        state,
    input  fpb_tgt_e          tgt,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pd,
    input  logic              frst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              fl_adv_n,
    output logic              fl_rst_n,
    output logic              ps_ce1_n,
    output logic              ps_ce2,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic [LANES-1:0]  ps_be_n
);
    logic in_bus, in_pulse, is_fl, is_ps;

    always_comb begin
        in_bus   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
        in_pulse = (state == ST_PULSE);
        is_fl    = (tgt == TGT_FLASH);
        is_ps    = (tgt == TGT_PSRAM);
        mem_addr = addr;
        dq_out   = wdata;
        fl_ce_n  = !(in_pulse && is_fl);
        fl_oe_n  = !(in_pulse && is_fl && !wr);
        fl_we_n  = !(in_pulse && is_fl && wr);
        fl_adv_n = !(is_fl && ((state == ST_SETUP) || in_pulse));
        fl_rst_n = !frst;
        ps_ce1_n = !(in_pulse && is_ps);
        ps_ce2   = !pd;
        ps_oe_n  = !(in_pulse && is_ps && !wr);
        ps_we_n  = !(in_pulse && is_ps && wr);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dq_oe[l]   = in_bus && wr && (is_fl || be[l]);
        assign ps_be_n[l] = !(in_pulse && is_ps && be[l]);
    end

    // R3
    one_die_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_ce_n && !ps_ce1_n && ps_ce2));
    // R4
    fl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (ps_oe_n && ps_ce1_n && (dq_oe == '0)));
    // R4
    ps_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_oe_n |-> (fl_oe_n && fl_ce_n && (dq_oe == '0)));
    // R5
    latch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |-> !fl_adv_n);
    // R5
    latch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_adv_n) |-> $stable(mem_addr));
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(mem_addr) && $stable(dq_out) && (dq_oe == '1)));
    // R9
    pd_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_ce2 |-> ps_ce1_n);
    // R10
    rst_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rst_n |-> fl_ce_n);
endmodule

// File: rtl/fpb_shared_bus_ctrl.sv
module fpb_shared_bus_ctrl
    import fpb_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int SHARED_W  = 20,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              pwrdn_req,
    input  logic              flash_rst_req,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [1:0]        dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              fl_adv_n,
    output logic              fl_rst_n,
    output logic              ps_ce1_n,
    output logic              ps_ce2,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic              ps_ub_n,
    output logic              ps_lb_n
);
    localparam int LANES   = DATA_W / 8;
    localparam int HI_W    = ADDR_W - SHARED_W;
    localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PUL_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HLD_LD = CNT_W'(HOLD_CYC - 1);

    fpb_state_e        state_q, state_d;
    fpb_tgt_e          tgt_q, last_tgt_q, req_tgt;
    logic              wr_q, last_wr_q, last_valid_q, reexit_q;
    logic              pd_q, frst_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, lane_mask;
    logic [LANES-1:0]  be_q, ps_be_n;
    logic              refuse, need_gap;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    assign req_tgt = fpb_tgt_e'(req_target);

    fpb_req_check #(.HI_W(HI_W)) u_check (
        .tgt        (req_tgt),
        .wr         (req_write),
        .addr_hi    (req_addr[ADDR_W-1:SHARED_W]),
        .pd         (pwrdn_req),
        .frst       (flash_rst_req),
        .last_valid (last_valid_q),
        .last_tgt   (last_tgt_q),
        .last_wr    (last_wr_q),
        .reexit     (reexit_q),
        .refuse     (refuse),
        .need_gap   (need_gap)
    );

    fpb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase counter loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (refuse) begin
                        state_d = ST_FAULT;
                    end else if (need_gap) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SET_LD;
                    end
                end
            end
            ST_GAP: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SET_LD;
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PUL_LD;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign lane_mask[l*8 +: 8] = ((tgt_q == TGT_FLASH) || be_q[l]) ? 8'hFF : 8'h00;
    end

    // request, history and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q        <= TGT_FLASH;
            wr_q         <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            be_q         <= '0;
            err_q        <= 1'b0;
            rdata_q      <= '0;
            last_valid_q <= 1'b0;
            last_tgt_q   <= TGT_FLASH;
            last_wr_q    <= 1'b0;
            reexit_q     <= 1'b0;
            pd_q         <= 1'b0;
            frst_q       <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                pd_q   <= pwrdn_req;
                frst_q <= flash_rst_req;
                if (flash_rst_req) begin
                    reexit_q <= 1'b1;
                end
                if (req_valid) begin
                    tgt_q   <= req_tgt;
                    wr_q    <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    be_q    <= LANES'(req_be);
                    err_q   <= refuse;
                    rdata_q <= '0;
                    if (!refuse && (req_tgt == TGT_FLASH)) begin
                        reexit_q <= 1'b0;
                    end
                end
            end
            if ((state_q == ST_PULSE) && tmr_zero && !wr_q) begin
                rdata_q <= dq_in & lane_mask;
            end
            if ((state_q == ST_HOLD) && tmr_zero) begin
                last_valid_q <= 1'b1;
                last_tgt_q   <= tgt_q;
                last_wr_q    <= wr_q;
            end
        end
    end

    fpb_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .tgt      (tgt_q),
        .wr       (wr_q),
        .be       (be_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .pd       (pd_q),
        .frst     (frst_q),
        .mem_addr (mem_addr),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .fl_ce_n  (fl_ce_n),
        .fl_oe_n  (fl_oe_n),
        .fl_we_n  (fl_we_n),
        .fl_adv_n (fl_adv_n),
        .fl_rst_n (fl_rst_n),
        .ps_ce1_n (ps_ce1_n),
        .ps_ce2   (ps_ce2),
        .ps_oe_n  (ps_oe_n),
        .ps_we_n  (ps_we_n),
        .ps_be_n  (ps_be_n)
    );

    assign ps_ub_n = ps_be_n[LANES-1];
    assign ps_lb_n = ps_be_n[0];
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign err     = err_q;
    assign rdata   = rdata_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R8
    refused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (fl_ce_n && ps_ce1_n && (dq_oe == '0)));
endmodule

// File: tb/fpb_shared_bus_ctrl_tb_top.sv
module fpb_shared_bus_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_target = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        pwrdn_req = 1'b0, flash_rst_req = 1'b0;
    logic        busy, done, err;
    logic [15:0] rdata, dq_out, dq_in;
    logic [22:0] mem_addr;
    logic [1:0]  dq_oe;
    logic        fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, fl_rst_n;
    logic        ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpb_shared_bus_ctrl #(
        .ADDR_W(23), .SHARED_W(20), .DATA_W(16),
        .SETUP_CYC(2), .PULSE_CYC(3), .HOLD_CYC(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .pwrdn_req(pwrdn_req), .flash_rst_req(flash_rst_req),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .mem_addr(mem_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_adv_n(fl_adv_n),
        .fl_rst_n(fl_rst_n), .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2),
        .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n)
    );

    // memory die models
    logic [15:0] fl_mem [16];
    logic [15:0] ps_mem [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                fl_mem[i] = 16'hFFFF;
                ps_mem[i] = 16'h0000;
            end
        end else begin
            if (!fl_ce_n && !fl_we_n && dq_oe == 2'b11)
                fl_mem[mem_addr[3:0]] = dq_out;
            if (!ps_ce1_n && ps_ce2 && !ps_we_n) begin
                if (!ps_ub_n && dq_oe[1]) ps_mem[mem_addr[3:0]][15:8] = dq_out[15:8];
                if (!ps_lb_n && dq_oe[0]) ps_mem[mem_addr[3:0]][7:0]  = dq_out[7:0];
            end
        end
    end

    always_comb begin
        if (!fl_ce_n && !fl_oe_n)
            dq_in = fl_mem[mem_addr[3:0]];
        else if (!ps_ce1_n && ps_ce2 && !ps_oe_n)
            dq_in = {(!ps_ub_n) ? ps_mem[mem_addr[3:0]][15:8] : 8'hA5,
                     (!ps_lb_n) ? ps_mem[mem_addr[3:0]][7:0]  : 8'h5A};
        else
            dq_in = 16'h0000;
    end

    // cycle counter and bus watchers
    int cyc = 0;
    int viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r6 = 0, seen_r6 = 0;
    int ps_sel_cnt = 0, lo_lane_cnt = 0, hi_lane_cnt = 0;
    logic        prev_we = 1'b1;
    logic [22:0] prev_addr = '0;
    logic [15:0] prev_dq = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_ce_n && !ps_ce1_n && ps_ce2) viol_r3++;
            if (!fl_oe_n && (!ps_oe_n || dq_oe != 2'b00)) viol_r4++;
            if (!ps_oe_n && (!fl_oe_n || dq_oe != 2'b00)) viol_r4++;
            if (!fl_ce_n && fl_adv_n) viol_r5++;
            if (!busy && !fl_adv_n) viol_r5++;
            if (!prev_we && fl_we_n) begin
                seen_r6++;
                if (mem_addr !== prev_addr || dq_out !== prev_dq || dq_oe != 2'b11) viol_r6++;
            end
            if (!ps_ce1_n) ps_sel_cnt++;
            if (dq_oe[0]) lo_lane_cnt++;
            if (dq_oe[1]) hi_lane_cnt++;
            prev_we   <= fl_we_n;
            prev_addr <= mem_addr;
            prev_dq   <= dq_out;
        end
    end

    // scoreboard
    typedef struct {
        logic [15:0] rd;
        logic        er;
        int          lat;
        int          acc;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    int mon_total = 0, mon_bad = 0;

    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n && done) begin
            mon_total++;
            if (sb_q.size() == 0) begin
                mon_bad++;
                $display("FAIL R12 unexpected done: actual=1 expected=0");
            end else begin
                e = sb_q.pop_front();
                if (rdata !== e.rd || err !== e.er || (cyc - e.acc) != e.lat) begin
                    mon_bad++;
                    $display("FAIL %s: actual rdata=%h err=%b lat=%0d expected rdata=%h err=%b lat=%0d",
                             e.tag, rdata, err, cyc - e.acc, e.rd, e.er, e.lat);
                end
            end
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic issue(input logic t, input logic w, input logic [22:0] a,
                         input logic [15:0] d, input logic [1:0] b,
                         input logic [15:0] xr, input logic xe, input int xl,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_target = t; req_write = w;
        req_addr = a; req_wdata = d; req_be = b;
        @(posedge clk);
        #1;
        e.rd = xr; e.er = xe; e.lat = xl; e.acc = cyc; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic access(input logic t, input logic w, input logic [22:0] a,
                          input logic [15:0] d, input logic [1:0] b,
                          input logic [15:0] xr, input logic xe, input int xl,
                          input string tag);
        issue(t, w, a, d, b, xr, xe, xl, tag);
        wait_idle();
    endtask

    localparam logic FL = 1'b0, PS = 1'b1;
    localparam int LN = 6, LG = 7, LF = 0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
        $finish;
    end

    initial begin : stim
        int snap_ps, snap_lo, snap_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n && fl_adv_n, "R1 flash enables", {fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n}, 4'hF);
        chk(ps_ce1_n && ps_oe_n && ps_we_n, "R1 psram enables", {ps_ce1_n, ps_oe_n, ps_we_n}, 3'h7);
        chk(fl_rst_n && ps_ce2, "R1 reset and power select", {fl_rst_n, ps_ce2}, 2'h3);
        chk(dq_oe == 2'b00 && !busy, "R1 bus released, idle", {dq_oe, busy}, 0);

        // R2 R6: flash write, no previous access
        access(FL, 1, 23'h000003, 16'h1234, 2'b11, 16'h0000, 0, LN, "R2 flash write");
        // R11: direction change inserts turnaround
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h1234, 0, LG, "R11 flash read after write");
        // R8 negative: flash uses high address bits, R11 no gap
        access(FL, 0, 23'h700003, 16'h0, 2'b11, 16'h1234, 0, LN, "R8 R11 flash high address");
        // R7 full word psram write/read
        snap_lo = lo_lane_cnt; snap_hi = hi_lane_cnt;
        access(PS, 1, 23'h000005, 16'hABCD, 2'b11, 16'h0000, 0, LG, "R11 psram write after flash");
        chk(lo_lane_cnt > snap_lo && hi_lane_cnt > snap_hi, "R7 both lanes driven", lo_lane_cnt - snap_lo, 3);
        access(PS, 0, 23'h000005, 16'h0, 2'b11, 16'hABCD, 0, LG, "R2 psram read");
        // R7 upper byte only write
        snap_lo = lo_lane_cnt; snap_hi = hi_lane_cnt;
        access(PS, 1, 23'h000005, 16'h1199, 2'b10, 16'h0000, 0, LG, "R7 upper byte write");
        chk(lo_lane_cnt == snap_lo, "R7 lower lane undriven", lo_lane_cnt - snap_lo, 0);
        chk(hi_lane_cnt > snap_hi, "R7 upper lane driven", hi_lane_cnt - snap_hi, 3);
        access(PS, 0, 23'h000005, 16'h0, 2'b11, 16'h11CD, 0, LG, "R7 merged word");
        access(PS, 0, 23'h000005, 16'h0, 2'b01, 16'h00CD, 0, LN, "R7 lower byte read");
        // R8 psram address beyond 20 bits
        snap_ps = ps_sel_cnt;
        access(PS, 0, 23'h100005, 16'h0, 2'b11, 16'h0000, 1, LF, "R8 psram high address");
        chk(ps_sel_cnt == snap_ps, "R8 no psram select", ps_sel_cnt - snap_ps, 0);
        // R12 busy and ignored request
        issue(PS, 0, 23'h000005, 16'h0, 2'b11, 16'h11CD, 0, LN, "R12 read during ignore");
        chk(busy, "R12 busy after accept", busy, 1);
        req_valid = 1'b1; req_target = PS; req_write = 1'b1;
        req_addr = 23'h000006; req_wdata = 16'hFFFF; req_be = 2'b11;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        access(PS, 0, 23'h000006, 16'h0, 2'b11, 16'h0000, 0, LN, "R12 ignored write absent");
        // R9 deep power-down
        pwrdn_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ps_ce2, "R9 power select low", ps_ce2, 0);
        snap_ps = ps_sel_cnt;
        access(PS, 0, 23'h000005, 16'h0, 2'b11, 16'h0000, 1, LF, "R9 psram refused");
        chk(ps_sel_cnt == snap_ps, "R9 no psram select", ps_sel_cnt - snap_ps, 0);
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h1234, 0, LG, "R9 flash during power-down");
        pwrdn_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(ps_ce2, "R9 power select restored", ps_ce2, 1);
        access(PS, 0, 23'h000005, 16'h0, 2'b11, 16'h11CD, 0, LG, "R9 psram after wake");
        // R10 flash reset and re-entry
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h1234, 0, LG, "R11 flash after psram");
        flash_rst_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(!fl_rst_n && fl_ce_n, "R10 reset driven, flash deselected", {fl_rst_n, fl_ce_n}, 1);
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h0000, 1, LF, "R10 flash refused in reset");
        flash_rst_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(fl_rst_n, "R10 reset released", fl_rst_n, 1);
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h1234, 0, LG, "R10 first flash after reset");
        access(FL, 0, 23'h000003, 16'h0, 2'b11, 16'h1234, 0, LN, "R10 second flash after reset");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R2 every request completed", sb_q.size(), 0);
        chk(viol_r3 == 0, "R3 single die selected", viol_r3, 0);
        chk(viol_r4 == 0, "R4 no read contention", viol_r4, 0);
        chk(viol_r5 == 0, "R5 latch strobe window", viol_r5, 0);
        chk(viol_r6 == 0 && seen_r6 > 0, "R6 write hold", viol_r6, 0);
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end
endmodule